// File: doc/BRIEF.md
# Bus-Sequenced Four-Operation Processor

This block is a small processor built around one shared 16-bit data bus. Eight general registers, an operand latch, a result latch and a 9-bit instruction latch all take their data from that bus. A one-hot multiplexer picks exactly one source for it. A control unit, paced by a 2-bit step counter, raises the load and drive enables that each instruction needs in each step.

Instruction words and immediate operands share the same 16-bit input. A host presents an instruction word while `run` is high, then presents the immediate in the following cycle if the instruction needs one. It watches `done` to learn when the next word may follow. The value on the internal bus is brought out on every cycle, so the host can observe each transfer. In particular, a move of a register onto itself shows that register's contents in the cycle where `done` is high.

Top module: `mproc_core`

## Requirements
- R1: In step T0 with `run` high, the instruction latch takes `din[15:7]` and ignores `din[6:0]`. The latched word holds the opcode in bits 8:6, the destination index Rx in bits 5:3 and the source index Ry in bits 2:0. The latch does not change in any other step.
- R2: Opcode 000 (move) drives Ry onto the bus in T1 and writes it into Rx. `done` is high in that T1, so the instruction takes two cycles. At most one general register is written in any cycle.
- R3: Opcode 001 (load immediate) drives the value on `din` in T1 onto the bus and writes it into Rx. `done` is high in that T1.
- R4: Opcode 010 (add) takes four cycles. T1 copies Rx into the operand latch. T2 drives Ry and stores the sum in the result latch. T3 drives the result latch onto the bus, writes it into Rx and raises `done`. The sum wraps modulo 2^16.
- R5: Opcode 011 (subtract) follows the same steps as add but stores Rx − Ry, wrapping modulo 2^16. This includes the case Rx = Ry.
- R6: After the step that raises `done`, the step counter returns to T0, so instructions can follow back to back with no idle cycle.
- R7: While `run` is low, the step counter holds, `done` stays low and no register is written. A paused add or subtract resumes in the step where it stopped and still gives the correct result.
- R8: A synchronous reset clears the step counter and all registers to 0. It holds `done` low and the bus at 0, and it abandons any instruction in progress.
- R9: Opcodes 100 to 111 complete in T1 with `done` high and write no register.
- R10: At most one bus source is selected in any cycle. The bus reads 0 when none is selected, including during T1 of opcodes 100 to 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows the step counter and all enables to proceed |
| din | input | DATA_W | Instruction word in T0, immediate operand in T1 of a load immediate |
| done | output | 1 | High in the final step of each instruction |
| bus_out | output | DATA_W | Current value of the shared bus |

## Verification
The hardest conditions to reach from the ports are a stall or a reset that lands in the middle of a four-step arithmetic instruction. The stimulus for the stall lowers `run` after T1 of an add has loaded the operand latch, holds it low for several cycles, and then checks that `done` arrives exactly that many cycles late with the correct sum. The stimulus for the reset raises `rst` during T2. Reads that move each register onto itself then show every register at zero. These reads also show that nothing was written while the processor was stalled or ran an undefined opcode.

// File: rtl/mproc_pkg.sv
package mproc_pkg;

    localparam int REG_N = 8;
    localparam int IDX_W = $clog2(REG_N);
    localparam int OP_W  = 3;
    localparam int IR_W  = OP_W + 2 * IDX_W;
    localparam int SRC_N = REG_N + 2;
    localparam int SRC_G   = REG_N;
    localparam int SRC_DIN = REG_N + 1;

    typedef enum logic [1:0] {
        STEP_T0 = 2'd0,
        STEP_T1 = 2'd1,
        STEP_T2 = 2'd2,
        STEP_T3 = 2'd3
    } step_t;

    typedef enum logic [OP_W-1:0] {
        OP_MV  = 3'd0,
        OP_MVI = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3
    } op_t;

    typedef struct packed {
        logic             ir_ld;
        logic [REG_N-1:0] r_out;
        logic [REG_N-1:0] r_in;
        logic             g_out;
        logic             din_out;
        logic             a_in;
        logic             g_in;
        logic             sub;
        logic             done;
    } ctrl_t;

    function automatic logic [OP_W-1:0] ir_op(input logic [IR_W-1:0] ir);
        return ir[IR_W-1 -: OP_W];
    endfunction

    function automatic logic [IDX_W-1:0] ir_rx(input logic [IR_W-1:0] ir);
        return ir[2*IDX_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] ir_ry(input logic [IR_W-1:0] ir);
        return ir[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/mproc_ctrl.sv
module mproc_ctrl
    import mproc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [IR_W-1:0] ir,
    output step_t           step,
    output ctrl_t           ctl
);

    logic [OP_W-1:0]  op;
    logic [IDX_W-1:0] rx;
    logic [IDX_W-1:0] ry;

    assign op = ir_op(ir);
    assign rx = ir_rx(ir);
    assign ry = ir_ry(ir);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= STEP_T0;
        end else if (run) begin
            if (ctl.done) step <= STEP_T0;
            else          step <= step_t'(step + 2'd1);
        end
    end

    always_comb begin
        ctl = '0;
        if (run && !rst) begin
            unique case (step)
                STEP_T0: ctl.ir_ld = 1'b1;
                STEP_T1: begin
                    unique case (op)
                        OP_MV: begin
                            ctl.r_out[ry] = 1'b1;
                            ctl.r_in[rx]  = 1'b1;
                            ctl.done      = 1'b1;
                        end
                        OP_MVI: begin
                            ctl.din_out  = 1'b1;
                            ctl.r_in[rx] = 1'b1;
                            ctl.done     = 1'b1;
                        end
                        OP_ADD, OP_SUB: begin
                            ctl.r_out[rx] = 1'b1;
                            ctl.a_in      = 1'b1;
                        end
                        default: ctl.done = 1'b1;
                    endcase
                end
                STEP_T2: begin
                    if (op == OP_ADD || op == OP_SUB) begin
                        ctl.r_out[ry] = 1'b1;
                        ctl.g_in      = 1'b1;
                        ctl.sub       = (op == OP_SUB);
                    end else begin
                        ctl.done = 1'b1;
                    end
                end
                STEP_T3: begin
                    if (op == OP_ADD || op == OP_SUB) begin
                        ctl.g_out    = 1'b1;
                        ctl.r_in[rx] = 1'b1;
                    end
                    ctl.done = 1'b1;
                end
                default: ctl = '0;
            endcase
        end
    end

endmodule

// File: rtl/mproc_regs.sv
module mproc_regs #(
    parameter int DATA_W = 16,
    parameter int REG_N  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_N-1:0]  wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q [REG_N]
);

    for (genvar i = 0; i < REG_N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= '0;
            else if (wr_en[i]) q[i] <= wdata;
        end
    end

endmodule

// File: rtl/mproc_bus.sv
module mproc_bus #(
    parameter int DATA_W = 16,
    parameter int SRC_N  = 10
) (
    input  logic [SRC_N-1:0]  sel,
    input  logic [DATA_W-1:0] src [SRC_N],
    output logic [DATA_W-1:0] bus
);

    logic [DATA_W-1:0] acc [SRC_N+1];

    assign acc[0] = '0;
    for (genvar i = 0; i < SRC_N; i++) begin : g_or
        assign acc[i+1] = acc[i] | ({DATA_W{sel[i]}} & src[i]);
    end
    assign bus = acc[SRC_N];

endmodule

// File: rtl/mproc_alu.sv
module mproc_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] y
);

    assign y = sub ? (a - b) : (a + b);

endmodule

// File: rtl/mproc_core.sv
module mproc_core
    import mproc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] bus_out
);

    step_t             step_q;
    ctrl_t             ctl;
    logic [IR_W-1:0]   ir_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] g_q;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] regs [REG_N];
    logic [DATA_W-1:0] srcs [SRC_N];
    logic [SRC_N-1:0]  sel;

    mproc_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .ir   (ir_q),
        .step (step_q),
        .ctl  (ctl)
    );

    mproc_regs #(.DATA_W(DATA_W), .REG_N(REG_N)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctl.r_in),
        .wdata (bus),
        .q     (regs)
    );

    for (genvar i = 0; i < REG_N; i++) begin : g_src
        assign srcs[i] = regs[i];
    end
    assign srcs[SRC_G]   = g_q;
    assign srcs[SRC_DIN] = din;
    assign sel = {ctl.din_out, ctl.g_out, ctl.r_out};

    mproc_bus #(.DATA_W(DATA_W), .SRC_N(SRC_N)) u_bus (
        .sel (sel),
        .src (srcs),
        .bus (bus)
    );

    mproc_alu #(.DATA_W(DATA_W)) u_alu (
        .a   (a_q),
        .b   (bus),
        .sub (ctl.sub),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
            a_q  <= '0;
            g_q  <= '0;
        end else begin
            if (ctl.ir_ld) ir_q <= din[DATA_W-1 -: IR_W];
            if (ctl.a_in)  a_q  <= bus;
            if (ctl.g_in)  g_q  <= alu_y;
        end
    end

    assign done    = ctl.done;
    assign bus_out = bus;

endmodule

// File: rtl/mproc_core_chk.sv
module mproc_core_chk
    import mproc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            run,
    input step_t           step,
    input ctrl_t           ctl,
    input logic [IR_W-1:0] ir
);

    AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.din_out, ctl.g_out, ctl.r_out})); // R10

    AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl.r_in)); // R2

    AST_IR_ONLY_AT_T0: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_T0) |=> $stable(ir)); // R1

    AST_STALL_HOLDS_STEP: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(step)); // R7

    AST_STALL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!ctl.done && ctl.r_in == '0 && !ctl.g_in && !ctl.a_in)); // R7

    AST_DONE_CLEARS_STEP: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> (step == STEP_T0)); // R6

    AST_ARITH_REACHES_T3: assert property (@(posedge clk) disable iff (rst)
        (run && step == STEP_T2 && ctl.g_in) |=> (step == STEP_T3)); // R4

    AST_SUB_LOADS_RESULT: assert property (@(posedge clk) disable iff (rst)
        ctl.sub |-> ctl.g_in); // R5

    AST_RESET_TO_T0: assert property (@(posedge clk)
        rst |=> (step == STEP_T0)); // R8

endmodule

bind mproc_core mproc_core_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .step (step_q),
    .ctl  (ctl),
    .ir   (ir_q)
);

// File: tb/mproc_core_bench.sv
module mproc_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic [DW-1:0] din = '0;
    logic          done;
    logic [DW-1:0] bus_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    mproc_core #(.DATA_W(DW)) u_mproc_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .din     (din),
        .done    (done),
        .bus_out (bus_out)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [8];

    logic [DW-1:0] q_bus [$];
    int            q_cyc [$];
    string         q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every done pops one expected item
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q_bus.size() == 0) begin
                check(1'b0, "R6 done with no instruction pending", 1, 0);
            end else begin
                logic [DW-1:0] eb;
                int ec;
                string tg;
                eb = q_bus.pop_front();
                ec = q_cyc.pop_front();
                tg = q_tag.pop_front();
                check(bus_out == eb, {tg, " bus"}, int'(bus_out), int'(eb));
                check(cyc == ec, {tg, " done cycle"}, cyc, ec);
            end
        end
    end

    // driver: issues one instruction and pushes its expected result
    task automatic issue(input logic [2:0] op, input logic [2:0] rx, input logic [2:0] ry,
                         input logic [DW-1:0] imm, input int pause, input string tag);
        logic [DW-1:0] exp;
        int lat;
        int c0;
        case (op)
            3'd0: begin exp = model[ry]; lat = 1; end
            3'd1: begin exp = imm; lat = 1; end
            3'd2: begin exp = model[rx] + model[ry]; lat = 3; end
            3'd3: begin exp = model[rx] - model[ry]; lat = 3; end
            default: begin exp = '0; lat = 1; end
        endcase
        @(posedge clk); #1;
        run = 1'b1;
        din = {op, rx, ry, 7'h5A};
        c0  = cyc;
        q_bus.push_back(exp);
        q_cyc.push_back(c0 + lat + ((lat == 3) ? pause : 0));
        q_tag.push_back(tag);
        @(posedge clk); #1;
        din = (op == 3'd1) ? imm : 16'hBEEF;
        if (lat == 3) begin
            @(posedge clk); #1;
            if (pause > 0) begin
                run = 1'b0;
                din = {3'd1, 3'd7, 3'd7, 7'h00};
                repeat (pause) begin
                    @(negedge clk);
                    check(done == 1'b0, "R7 done while stalled", int'(done), 0);
                    @(posedge clk); #1;
                end
                run = 1'b1;
                din = 16'hBEEF;
            end
            @(posedge clk); #1;
        end
        if (op <= 3'd3 && op != 3'd0 || op == 3'd0) begin
            if (op <= 3'd3) model[rx] = exp;
        end
    endtask

    task automatic read_all(input string tag);
        for (int k = 0; k < 8; k++) issue(3'd0, 3'(k), 3'(k), '0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        if (!finished) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = '0;
        rst = 1'b1; run = 1'b1; din = {3'd1, 3'd0, 3'd0, 7'h00};
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 done low in reset", int'(done), 0);
        check(bus_out == '0, "R8 bus zero in reset", int'(bus_out), 0);
        @(posedge clk); #1;
        rst = 1'b0; run = 1'b0;

        read_all("R8 registers zero after reset");

        issue(3'd1, 3'd0, 3'd0, 16'h1234, 0, "R3 load R0 (R1 low bits ignored)");
        issue(3'd1, 3'd1, 3'd0, 16'hFFFF, 0, "R3 load R1");
        issue(3'd1, 3'd4, 3'd0, 16'h0001, 0, "R3 load R4");
        issue(3'd0, 3'd2, 3'd0, '0, 0, "R2 move R0 to R2");
        issue(3'd0, 3'd3, 3'd1, '0, 0, "R2 move R1 to R3");
        issue(3'd0, 3'd2, 3'd2, '0, 0, "R2 read R2");
        issue(3'd2, 3'd0, 3'd4, '0, 0, "R4 add R0+R4");
        issue(3'd2, 3'd1, 3'd4, '0, 0, "R4 add wraps R1+R4");
        issue(3'd3, 3'd4, 3'd0, '0, 0, "R5 sub wraps R4-R0");
        issue(3'd3, 3'd5, 3'd5, '0, 0, "R5 sub same register");
        issue(3'd2, 3'd2, 3'd2, '0, 0, "R4 add R2+R2");
        issue(3'd5, 3'd6, 3'd0, '0, 0, "R9 undefined opcode 101");
        issue(3'd7, 3'd7, 3'd7, '0, 0, "R9 R10 undefined opcode 111 bus zero");
        read_all("R9 R6 no write by undefined opcodes");

        // stall while idle with a load instruction on din
        @(posedge clk); #1;
        run = 1'b0;
        din = {3'd1, 3'd3, 3'd0, 7'h00};
        repeat (4) begin
            @(negedge clk);
            check(done == 1'b0, "R7 idle done low", int'(done), 0);
            check(bus_out == '0, "R7 R10 idle bus zero", int'(bus_out), 0);
            @(posedge clk); #1;
        end
        issue(3'd2, 3'd3, 3'd0, '0, 3, "R7 add resumed after stall");
        read_all("R7 registers after stall");

        // reset during T2 of a subtract
        @(posedge clk); #1;
        run = 1'b1; din = {3'd3, 3'd0, 3'd1, 7'h00};
        @(posedge clk); #1;
        din = 16'hBEEF;
        @(posedge clk); #1;
        rst = 1'b1; run = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 done low on mid-instruction reset", int'(done), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        for (int k = 0; k < 8; k++) model[k] = '0;
        read_all("R8 registers cleared mid-instruction");

        @(posedge clk); #1;
        run = 1'b0;
        repeat (3) @(posedge clk);
        check(q_bus.size() == 0, "R6 every instruction completed", q_bus.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule